// File: doc/BRIEF.md
# Fourth-Order Recursive Crossover Filter

This block filters a mono audio stream with a fourth-order recursive (IIR) section, the kind used to split a signal between loudspeaker drivers. A Linkwitz-Riley low-pass or high-pass branch is a typical use. Each sample is a signed 24-bit value that comes with a one-cycle start strobe. Nine signed fixed-point coefficients arrive on parallel inputs. An external controller has already scaled them by 2^FRACT_BITS. Five of them weight the current and four past inputs, and four weight the past outputs.

All nine products come from one multiplier that is shared in time. A fixed schedule walks through the terms, one product per clock. The sample is widened with 8 fractional bits. Each product is shifted back by FRACT_BITS and added to, or subtracted from, a wide accumulator. The result is saturated and stored in the output history. It is then presented as a 24-bit sample together with a one-cycle valid strobe. The block holds its own four-deep input history and four-deep output history. A synchronous reset clears them.

Top module: `xover4_iir`

## Requirements
- R1: While `rst` is high at a clock edge, `sample_out`, `sync_out`, the accumulator and all eight history registers become zero, and the sequencer returns to idle. A later impulse therefore gives the response of a filter at rest.
- R2: The result is y = f0·x[n] + f1·x[n-1] + f2·x[n-2] + f3·x[n-3] + f4·x[n-4] − g1·y[n-1] − g2·y[n-2] − g3·y[n-3] − g4·y[n-4]. Here f0..f4 are on `ff0`..`ff4` and g1..g4 are on `fb1`..`fb4`. The feedback terms are subtracted.
- R3: The input sample enters as x·2^8, a 32-bit Q23.8 value. Each product is arithmetically shifted right by FRACT_BITS (rounding toward minus infinity) before it is accumulated. The output is the stored result shifted right arithmetically by 8.
- R4: When `sync_in` is sampled high in idle, `sync_out` goes high 11 cycles after the cycle in which `sync_in` was driven. It stays high for exactly one cycle. `sample_out` changes only in that cycle.
- R5: `sync_in` is ignored in every non-idle state, including the cycle in which `sync_out` is high. It causes no extra strobe and leaves the histories unchanged. The earliest next accepted start is 12 cycles after the previous one.
- R6: After each result, the input history shifts by one place and takes the new Q23.8 input. The output history shifts and takes the 32-bit Q23.8 result after saturation, with its 8 fractional bits kept, not the truncated 24-bit output.
- R7: A result above the 32-bit Q23.8 range clamps to 0x7FFFFFFF. A result below it clamps to 0x80000000. `sample_out` therefore saturates at 8388607 and −8388608 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | One-cycle start strobe for `sample_in` |
| sample_in | input | SAMPLE_W | Signed input sample |
| ff0 | input | COEF_W | Feed-forward coefficient for x[n] |
| ff1 | input | COEF_W | Feed-forward coefficient for x[n-1] |
| ff2 | input | COEF_W | Feed-forward coefficient for x[n-2] |
| ff3 | input | COEF_W | Feed-forward coefficient for x[n-3] |
| ff4 | input | COEF_W | Feed-forward coefficient for x[n-4] |
| fb1 | input | COEF_W | Feedback coefficient for y[n-1] |
| fb2 | input | COEF_W | Feedback coefficient for y[n-2] |
| fb3 | input | COEF_W | Feedback coefficient for y[n-3] |
| fb4 | input | COEF_W | Feedback coefficient for y[n-4] |
| sample_out | output | SAMPLE_W | Signed filtered sample |
| sync_out | output | 1 | One-cycle valid strobe for `sample_out` |

## Verification
The bench uses the default build: 24-bit samples, 8 input fractional bits, 40-bit coefficients and 30 fractional coefficient bits. These values give coefficients in the range ±512. That range makes a unity tap, a pure four-sample delay, a −1.0 feedback integrator and a ×4 overdrive all expressible exactly. The integrator exposes whether the output history keeps its fractional bits. The overdrive drives full-scale inputs into both saturation limits. Random stable coefficient sets with random, impulse and sine inputs cover the floor rounding of every product against a bit-exact model.

// File: rtl/xover4_iir.sv
module xover4_iir #(
  parameter int SAMPLE_W   = 24,
  parameter int FRAC_IN    = 8,
  parameter int COEF_W     = 40,
  parameter int FRACT_BITS = 30
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sync_in,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  input  logic signed [COEF_W-1:0]   ff0,
  input  logic signed [COEF_W-1:0]   ff1,
  input  logic signed [COEF_W-1:0]   ff2,
  input  logic signed [COEF_W-1:0]   ff3,
  input  logic signed [COEF_W-1:0]   ff4,
  input  logic signed [COEF_W-1:0]   fb1,
  input  logic signed [COEF_W-1:0]   fb2,
  input  logic signed [COEF_W-1:0]   fb3,
  input  logic signed [COEF_W-1:0]   fb4,
  output logic signed [SAMPLE_W-1:0] sample_out,
  output logic                       sync_out
);

  localparam int DATA_W = SAMPLE_W + FRAC_IN;
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = DATA_W + COEF_W - FRACT_BITS + 4;

  localparam logic [3:0] S_IDLE  = 4'd0;
  localparam logic [3:0] S_WRITE = 4'd10;
  localparam logic [3:0] S_DONE  = 4'd11;

  localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic [3:0]               step;
  logic signed [DATA_W-1:0] x_in, x_cur;
  logic signed [DATA_W-1:0] xh1, xh2, xh3, xh4;
  logic signed [DATA_W-1:0] yh1, yh2, yh3, yh4;
  logic signed [DATA_W-1:0] op_d, nxt_d, y_new;
  logic signed [COEF_W-1:0] op_c, nxt_c;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc, term;

  assign x_in  = {sample_in, {FRAC_IN{1'b0}}};
  assign prod  = op_d * op_c;
  assign term  = ACC_W'(prod >>> FRACT_BITS);
  assign y_new = (acc > SAT_HI) ? SAT_HI[DATA_W-1:0] :
                 (acc < SAT_LO) ? SAT_LO[DATA_W-1:0] : acc[DATA_W-1:0];

  always_comb begin
    case (step)
      4'd1:    begin nxt_d = xh1; nxt_c = ff1; end
      4'd2:    begin nxt_d = xh2; nxt_c = ff2; end
      4'd3:    begin nxt_d = xh3; nxt_c = ff3; end
      4'd4:    begin nxt_d = xh4; nxt_c = ff4; end
      4'd5:    begin nxt_d = yh1; nxt_c = fb1; end
      4'd6:    begin nxt_d = yh2; nxt_c = fb2; end
      4'd7:    begin nxt_d = yh3; nxt_c = fb3; end
      4'd8:    begin nxt_d = yh4; nxt_c = fb4; end
      default: begin nxt_d = '0;  nxt_c = '0;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= S_IDLE;
      acc        <= '0;
      op_d       <= '0;
      op_c       <= '0;
      x_cur      <= '0;
      xh1        <= '0;
      xh2        <= '0;
      xh3        <= '0;
      xh4        <= '0;
      yh1        <= '0;
      yh2        <= '0;
      yh3        <= '0;
      yh4        <= '0;
      sample_out <= '0;
      sync_out   <= 1'b0;
    end else begin
      case (step)
        S_IDLE: begin
          if (sync_in) begin
            x_cur <= x_in;
            op_d  <= x_in;
            op_c  <= ff0;
            step  <= 4'd1;
          end
        end
        S_WRITE: begin
          sample_out <= SAMPLE_W'(y_new >>> FRAC_IN);
          sync_out   <= 1'b1;
          yh1        <= y_new;
          yh2        <= yh1;
          yh3        <= yh2;
          yh4        <= yh3;
          xh1        <= x_cur;
          xh2        <= xh1;
          xh3        <= xh2;
          xh4        <= xh3;
          step       <= S_DONE;
        end
        S_DONE: begin
          sync_out <= 1'b0;
          step     <= S_IDLE;
        end
        default: begin
          if (step == 4'd1)      acc <= term;
          else if (step >= 4'd6) acc <= acc - term;
          else                   acc <= acc + term;
          op_d <= nxt_d;
          op_c <= nxt_c;
          step <= step + 4'd1;
        end
      endcase
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sync_out |=> !sync_out);

  a_r4_output_held: assert property (@(posedge clk) disable iff (rst)
    !sync_out |-> $stable(sample_out));

  a_r4_strobe_at_end: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> step == S_DONE);

  a_r5_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
    (step != S_IDLE && step != S_DONE && sync_in) |=> step == $past(step) + 4'd1);

  a_r6_history_matches_out: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> sample_out == SAMPLE_W'(yh1 >>> FRAC_IN));

endmodule

// File: tb/xover4_iir_tb_top.sv
module xover4_iir_tb_top;
  localparam int CLK_T = 10;
  localparam int FRACT = 30;
  localparam logic signed [39:0] ONE = 40'sd1 <<< FRACT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_in = 1'b0;
  logic signed [23:0] sample_in = '0;
  logic signed [39:0] cf [0:4];
  logic signed [39:0] cb [1:4];
  logic signed [23:0] sample_out;
  logic sync_out;

  logic signed [31:0] mx [1:4];
  logic signed [31:0] my [1:4];
  int checks = 0;
  int errors = 0;

  always #(CLK_T/2) clk = ~clk;

  xover4_iir #(.SAMPLE_W(24), .FRAC_IN(8), .COEF_W(40), .FRACT_BITS(FRACT)) dut_i (
    .clk(clk), .rst(rst), .sync_in(sync_in), .sample_in(sample_in),
    .ff0(cf[0]), .ff1(cf[1]), .ff2(cf[2]), .ff3(cf[3]), .ff4(cf[4]),
    .fb1(cb[1]), .fb2(cb[2]), .fb3(cb[3]), .fb4(cb[4]),
    .sample_out(sample_out), .sync_out(sync_out));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic signed [127:0] mac(input logic signed [39:0] c, input logic signed [31:0] d);
    logic signed [127:0] wc, wd;
    wc = c;
    wd = d;
    return (wc * wd) >>> FRACT;
  endfunction

  task automatic model_clear();
    for (int i = 1; i <= 4; i++) begin mx[i] = '0; my[i] = '0; end
  endtask

  task automatic model_step(input logic signed [23:0] x, output logic signed [23:0] e);
    logic signed [127:0] a;
    logic signed [31:0] xs, ys;
    xs = {x, 8'h00};
    a = mac(cf[0], xs);
    for (int i = 1; i <= 4; i++) a += mac(cf[i], mx[i]);
    for (int i = 1; i <= 4; i++) a -= mac(cb[i], my[i]);
    if (a > 128'sd2147483647) ys = 32'h7FFFFFFF;
    else if (a < -128'sd2147483648) ys = 32'h80000000;
    else ys = a[31:0];
    for (int i = 4; i > 1; i--) begin mx[i] = mx[i-1]; my[i] = my[i-1]; end
    mx[1] = xs;
    my[1] = ys;
    e = 24'(ys >>> 8);
  endtask

  task automatic set_coefs(input logic signed [39:0] f0, f1, f2, f3, f4, g1, g2, g3, g4);
    cf[0] = f0; cf[1] = f1; cf[2] = f2; cf[3] = f3; cf[4] = f4;
    cb[1] = g1; cb[2] = g2; cb[3] = g3; cb[4] = g4;
  endtask

  task automatic drive(input logic signed [23:0] x, input int busy_at, input string tag,
                       output logic signed [23:0] got);
    logic signed [23:0] e;
    int lat;
    model_step(x, e);
    @(negedge clk);
    sample_in = x;
    sync_in = 1'b1;
    lat = 0;
    for (int i = 1; i <= 11; i++) begin
      @(negedge clk);
      sync_in = (i == busy_at);
      if (sync_out && lat == 0) lat = i;
    end
    got = sample_out;
    check(lat == 11, "R4 latency", lat, 11);
    check(sample_out == e, tag, sample_out, e);
    @(negedge clk);
    sync_in = 1'b0;
    check(sync_out == 1'b0, "R4 one-cycle strobe", sync_out, 0);
    if (busy_at != 0) begin
      int extra = 0;
      for (int i = 0; i < 13; i++) begin
        @(negedge clk);
        if (sync_out) extra++;
      end
      check(extra == 0, "R5 busy start ignored", extra, 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(sample_out == 0, "R1 reset sample_out", sample_out, 0);
    check(sync_out == 0, "R1 reset sync_out", sync_out, 0);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic rand_coefs();
    for (int i = 0; i <= 4; i++) cf[i] = 40'(int'($urandom) >>> 3);
    for (int i = 1; i <= 4; i++) cb[i] = 40'(int'($urandom) >>> 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic signed [23:0] got;
    int unused_seed;
    unused_seed = $urandom(20240);
    set_coefs(ONE, 0, 0, 0, 0, 0, 0, 0, 0);
    model_clear();
    repeat (5) @(negedge clk);
    check(sample_out == 0, "R1 initial sample_out", sample_out, 0);
    check(sync_out == 0, "R1 initial sync_out", sync_out, 0);
    rst = 1'b0;

    // R2: unity tap passes the sample through unchanged
    for (int n = 0; n < 4; n++) begin
      logic signed [23:0] x;
      x = 24'($urandom);
      drive(x, 0, "R2 unity tap", got);
      check(got == x, "R2 unity equals input", got, x);
    end

    // R6: pure four-sample delay on ff4
    do_reset();
    set_coefs(0, 0, 0, 0, ONE, 0, 0, 0, 0);
    for (int n = 0; n < 6; n++) begin
      drive(n == 0 ? 24'sd1000 : 24'sd0, 0, "R6 delay line", got);
      check(got == (n == 4 ? 1000 : 0), "R6 delay tap position", got, n == 4 ? 1000 : 0);
    end

    // R6: integrator with half gain keeps fractional history: outputs 0,1,1,2
    do_reset();
    set_coefs(ONE >>> 1, 0, 0, 0, 0, -ONE, 0, 0, 0);
    for (int n = 0; n < 4; n++) begin
      int exp_i;
      exp_i = (n + 1) / 2;
      drive(24'sd1, 0, "R6 integrator", got);
      check(got == exp_i, "R6 fractional history", got, exp_i);
    end

    // R7: saturation both ways, history holds the clamped value
    do_reset();
    set_coefs(ONE <<< 2, 0, 0, 0, 0, 0, 0, 0, 0);
    drive(24'sd8388607, 0, "R7 positive clamp", got);
    check(got == 8388607, "R7 positive limit", got, 8388607);
    set_coefs(0, 0, 0, 0, 0, -ONE, 0, 0, 0);
    drive(24'sd0, 0, "R7 clamped history", got);
    check(got == 8388607, "R7 history clamped", got, 8388607);
    set_coefs(ONE <<< 2, 0, 0, 0, 0, 0, 0, 0, 0);
    drive(-24'sd8388608, 0, "R7 negative clamp", got);
    check(got == -8388608, "R7 negative limit", got, -8388608);

    // R5: start strobes while busy, including the strobe cycle itself
    do_reset();
    rand_coefs();
    drive(24'sd500000, 5, "R5 busy mid", got);
    drive(-24'sd300000, 11, "R5 busy at strobe", got);
    drive(24'sd123456, 0, "R5 history untouched", got);

    // R1: reset mid-stream, then impulse response from rest
    do_reset();
    for (int n = 0; n < 10; n++) drive(n == 0 ? 24'sd2000000 : 24'sd0, 0, "R1 impulse after reset", got);

    // R2 R3: random coefficients with random, impulse and sine inputs
    for (int set = 0; set < 4; set++) begin
      do_reset();
      rand_coefs();
      for (int n = 0; n < 40; n++) drive(24'($urandom), 0, "R2 R3 random input", got);
      do_reset();
      for (int n = 0; n < 12; n++) drive(n == 0 ? 24'sd4000000 : 24'sd0, 0, "R2 impulse", got);
      for (int n = 0; n < 48; n++) begin
        logic signed [23:0] s;
        s = 24'($rtoi(3000000.0 * $sin(2.0 * 3.14159265 * n / 24.0)));
        drive(s, 0, "R3 sine input", got);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule